// File: doc/BRIEF.md
# Tag-capturing reservation station

This block sits in front of one functional unit and holds a small pool of waiting operations. When an operation is issued, each of its two sources is looked up in a register status table. A source whose register has no pending writer is copied in as a value. A source whose register is pending is recorded as the tag of its producer. The destination register is then renamed to the tag that the issue side supplies, so later readers wait on that tag and not on the register name.

Results come back on a single broadcast bus that carries a tag and a value. Every waiting source whose tag matches takes the value directly from the bus. The architectural register file is written only when its status entry still names the broadcasting tag, so when two writes to one register overlap, the older one never reaches the file. When the unit signals that it is free, the oldest entry with both operands present is handed to it and its slot is released in the same cycle. A combinational read port shows the value of any architectural register and whether it is pending.

Top module: `rename_station`

## Requirements
- R1: After reset, `iss_ready` is 1, `disp_valid` is 0, and every architectural register reads 0 with `rd_pending` 0.
- R2: A source whose register is not pending is captured at issue as the register's current value, and that value appears on `disp_a` or `disp_b` when the entry dispatches.
- R3: A source whose register is pending waits on the producer tag. The entry does not dispatch before a broadcast with that tag. It captures `cdb_data` at that broadcast edge and can dispatch from the next cycle.
- R4: `disp_valid` is 1 only while `fu_ready` is 1 and some entry holds both operands. A dispatched entry is never visible before the cycle after its issue edge.
- R5: An accepted issue marks `iss_dst` pending under `iss_tag` from the next cycle. A later issue that reads that register waits on `iss_tag`.
- R6: A broadcast writes `cdb_data` into a register and clears its pending flag only if that register's status holds `cdb_tag`. A broadcast of an older writer's tag leaves the register's value and pending flag unchanged.
- R7: When more than one entry is ready, the one issued earliest dispatches first, whatever slot it occupies.
- R8: If the tag a source is waiting on is broadcast in the same cycle as the issue, the entry captures the broadcast value, not the tag.
- R9: When all slots are occupied, `iss_ready` is 0 and an asserted `iss_valid` is ignored: no entry is created and no register is renamed.
- R10: Each accepted entry dispatches exactly once, and its slot is free again, with `iss_ready` back at 1, in the cycle after its dispatch edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| iss_valid | input | 1 | Issue request |
| iss_ready | output | 1 | At least one slot is free |
| iss_op | input | OP_W | Operation code of the issued entry |
| iss_src1 | input | REG_W | First source register |
| iss_src2 | input | REG_W | Second source register |
| iss_dst | input | REG_W | Destination register to rename |
| iss_tag | input | TAG_W | Tag under which the result will be broadcast |
| cdb_valid | input | 1 | Result broadcast valid |
| cdb_tag | input | TAG_W | Tag of the broadcast result |
| cdb_data | input | DATA_W | Broadcast result value |
| fu_ready | input | 1 | Functional unit can accept an operation |
| disp_valid | output | 1 | An entry is handed to the unit this cycle |
| disp_op | output | OP_W | Operation code of the dispatched entry |
| disp_a | output | DATA_W | First operand value |
| disp_b | output | DATA_W | Second operand value |
| disp_tag | output | TAG_W | Destination tag of the dispatched entry |
| rd_reg | input | REG_W | Register read address |
| rd_data | output | DATA_W | Committed value of `rd_reg` |
| rd_pending | output | 1 | `rd_reg` has an outstanding writer |

## Verification
An issue or a broadcast takes effect at the rising edge that samples it. Rename state and register values show on the read port right after that edge, and a newly ready entry can show on the dispatch outputs in the cycle after that edge. Dispatch itself is combinational from `fu_ready` and the registered entries, so the slot frees at the same edge that the unit accepts the entry. The bench drives all inputs on the falling edge and reads outputs a fraction of a cycle later, so each sample shows the state the next rising edge will act on. A monitor compares every dispatch against a queue of expected entries kept in expected order, which checks both the values and the oldest-first ordering.

// File: rtl/rename_station_pkg.sv
package rename_station_pkg;
  typedef enum logic {
    SRC_WAIT = 1'b0,
    SRC_HAVE = 1'b1
  } src_state_e;
endpackage

// File: rtl/rs_reg_status.sv
module rs_reg_status #(
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 4,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ren_en,
  input  logic [REG_W-1:0]  ren_reg,
  input  logic [TAG_W-1:0]  ren_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic [REG_W-1:0]  src_reg [2],
  output logic [1:0]        src_have,
  output logic [DATA_W-1:0] src_val [2],
  output logic [TAG_W-1:0]  src_tag [2],
  input  logic [REG_W-1:0]  rd_reg,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pending
);

  logic [DATA_W-1:0]   val_q  [NUM_REGS];
  logic [TAG_W-1:0]    tag_q  [NUM_REGS];
  logic [NUM_REGS-1:0] busy_q, busy_n;
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] tag_we;

  // Broadcast matches the newest writer of a register
  always_comb begin
    for (int r = 0; r < NUM_REGS; r++) begin
      hit[r] = cdb_valid && busy_q[r] && (tag_q[r] == cdb_tag);
    end
  end

  // Next state: rename wins over the clear of the same register
  always_comb begin
    busy_n = busy_q;
    tag_we = '0;
    for (int r = 0; r < NUM_REGS; r++) begin
      if (hit[r]) busy_n[r] = 1'b0;
      if (ren_en && (ren_reg == REG_W'(r))) begin
        busy_n[r] = 1'b1;
        tag_we[r] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= '0;
      for (int r = 0; r < NUM_REGS; r++) begin
        val_q[r] <= '0;
        tag_q[r] <= '0;
      end
    end else begin
      busy_q <= busy_n;
      for (int r = 0; r < NUM_REGS; r++) begin
        if (hit[r])    val_q[r] <= cdb_data;
        if (tag_we[r]) tag_q[r] <= ren_tag;
      end
    end
  end

  // Operand lookup with same-cycle bypass from the broadcast bus
  always_comb begin
    for (int s = 0; s < 2; s++) begin
      src_tag[s] = tag_q[src_reg[s]];
      if (!busy_q[src_reg[s]]) begin
        src_have[s] = 1'b1;
        src_val[s]  = val_q[src_reg[s]];
      end else if (hit[src_reg[s]]) begin
        src_have[s] = 1'b1;
        src_val[s]  = cdb_data;
      end else begin
        src_have[s] = 1'b0;
        src_val[s]  = '0;
      end
    end
  end

  assign rd_data    = val_q[rd_reg];
  assign rd_pending = busy_q[rd_reg];

  // R5: the renamed register becomes pending under the issued tag
  p_rename_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ren_en |=> (busy_q[$past(ren_reg)] && (tag_q[$past(ren_reg)] == $past(ren_tag))));

  generate
    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg_chk
      // R6: no broadcast of the current tag, no change of the value
      p_stale_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !(cdb_valid && busy_q[g] && (tag_q[g] == cdb_tag)) |=> $stable(val_q[g]));
    end
  endgenerate

endmodule

// File: rtl/rs_slot.sv
module rs_slot
  import rename_station_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int TAG_W  = 4,
  parameter int OP_W   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [OP_W-1:0]   ld_op,
  input  logic [1:0]        ld_have,
  input  logic [DATA_W-1:0] ld_val [2],
  input  logic [TAG_W-1:0]  ld_tag [2],
  input  logic [TAG_W-1:0]  ld_dst,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              release_i,
  output logic              valid_o,
  output logic              ready_o,
  output logic [OP_W-1:0]   op_o,
  output logic [DATA_W-1:0] opa_o,
  output logic [DATA_W-1:0] opb_o,
  output logic [TAG_W-1:0]  dst_o
);

  logic              valid_q, valid_n;
  logic [OP_W-1:0]   op_q;
  logic [TAG_W-1:0]  dst_q;
  src_state_e        have_q [2];
  src_state_e        have_n [2];
  logic [DATA_W-1:0] val_q  [2];
  logic [DATA_W-1:0] val_d  [2];
  logic [TAG_W-1:0]  tag_q  [2];
  logic [1:0]        grab, val_we;

  always_comb begin
    valid_n = valid_q;
    if (release_i) valid_n = 1'b0;
    if (load_i)    valid_n = 1'b1;
    for (int s = 0; s < 2; s++) begin
      grab[s]   = valid_q && (have_q[s] == SRC_WAIT) && cdb_valid && (tag_q[s] == cdb_tag);
      val_we[s] = load_i || grab[s];
      val_d[s]  = load_i ? ld_val[s] : cdb_data;
      have_n[s] = have_q[s];
      if (grab[s]) have_n[s] = SRC_HAVE;
      if (load_i)  have_n[s] = src_state_e'(ld_have[s]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      op_q    <= '0;
      dst_q   <= '0;
      for (int s = 0; s < 2; s++) begin
        have_q[s] <= SRC_WAIT;
        val_q[s]  <= '0;
        tag_q[s]  <= '0;
      end
    end else begin
      valid_q <= valid_n;
      if (load_i) begin
        op_q  <= ld_op;
        dst_q <= ld_dst;
      end
      for (int s = 0; s < 2; s++) begin
        have_q[s] <= have_n[s];
        if (val_we[s]) val_q[s] <= val_d[s];
        if (load_i)    tag_q[s] <= ld_tag[s];
      end
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q && (have_q[0] == SRC_HAVE) && (have_q[1] == SRC_HAVE);
  assign op_o    = op_q;
  assign opa_o   = val_q[0];
  assign opb_o   = val_q[1];
  assign dst_o   = dst_q;

  // R9: only a free slot is loaded
  p_load_free_r9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |-> !valid_q);

  // R4: a slot is released only with both operands present
  p_release_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
    release_i |-> ready_o);

  generate
    for (genvar s = 0; s < 2; s++) begin : g_src_chk
      // R3: a matching broadcast is captured at that edge
      p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        grab[s] |=> ((have_q[s] == SRC_HAVE) && (val_q[s] == $past(cdb_data))));
    end
  endgenerate

endmodule

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int NUM_SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_SLOTS-1:0] slot_valid,
  input  logic [NUM_SLOTS-1:0] slot_ready,
  input  logic                 alloc_req,
  input  logic                 fu_ready,
  output logic                 can_alloc,
  output logic [NUM_SLOTS-1:0] alloc_oh,
  output logic [NUM_SLOTS-1:0] disp_oh
);

  // older_q[i][j] set: slot i was loaded before slot j
  logic [NUM_SLOTS-1:0] older_q [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] older_n [NUM_SLOTS];
  logic [NUM_SLOTS-1:0] first_free;
  logic [NUM_SLOTS-1:0] blocked;
  logic                 age_en;

  always_comb begin
    first_free = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      if (!slot_valid[i] && (first_free == '0)) first_free[i] = 1'b1;
    end
  end

  assign can_alloc = ~&slot_valid;
  assign alloc_oh  = alloc_req ? first_free : '0;
  assign age_en    = |alloc_oh;

  always_comb begin
    blocked = '0;
    for (int i = 0; i < NUM_SLOTS; i++) begin
      for (int j = 0; j < NUM_SLOTS; j++) begin
        if ((j != i) && slot_ready[j] && older_q[j][i]) blocked[i] = 1'b1;
      end
    end
  end

  assign disp_oh = slot_ready & ~blocked & {NUM_SLOTS{fu_ready}};

  always_comb begin
    older_n = older_q;
    for (int k = 0; k < NUM_SLOTS; k++) begin
      if (alloc_oh[k]) begin
        older_n[k] = '0;
        for (int j = 0; j < NUM_SLOTS; j++) begin
          if (j != k) older_n[j][k] = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_SLOTS; i++) older_q[i] <= '0;
    end else if (age_en) begin
      older_q <= older_n;
    end
  end

  // R7: at most one entry is granted per cycle
  p_one_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_oh));

  // R4: no grant while the unit is busy
  p_grant_needs_unit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (|disp_oh) |-> fu_ready);

  // R9: a full pool loads nothing
  p_full_no_alloc_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (&slot_valid) |-> (alloc_oh == '0));

endmodule

// File: rtl/rename_station.sv
module rename_station #(
  parameter int NUM_SLOTS = 4,
  parameter int NUM_REGS  = 8,
  parameter int DATA_W    = 16,
  parameter int TAG_W     = 4,
  parameter int OP_W      = 3,
  localparam int REG_W    = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              iss_valid,
  output logic              iss_ready,
  input  logic [OP_W-1:0]   iss_op,
  input  logic [REG_W-1:0]  iss_src1,
  input  logic [REG_W-1:0]  iss_src2,
  input  logic [REG_W-1:0]  iss_dst,
  input  logic [TAG_W-1:0]  iss_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_data,
  input  logic              fu_ready,
  output logic              disp_valid,
  output logic [OP_W-1:0]   disp_op,
  output logic [DATA_W-1:0] disp_a,
  output logic [DATA_W-1:0] disp_b,
  output logic [TAG_W-1:0]  disp_tag,
  input  logic [REG_W-1:0]  rd_reg,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_pending
);

  logic [NUM_SLOTS-1:0] alloc_oh, disp_oh, slot_valid, slot_ready;
  logic                 can_alloc, iss_fire;
  logic [REG_W-1:0]     src_reg  [2];
  logic [1:0]           src_have;
  logic [DATA_W-1:0]    src_val  [2];
  logic [TAG_W-1:0]     src_tag  [2];
  logic [OP_W-1:0]      s_op  [NUM_SLOTS];
  logic [DATA_W-1:0]    s_a   [NUM_SLOTS];
  logic [DATA_W-1:0]    s_b   [NUM_SLOTS];
  logic [TAG_W-1:0]     s_dst [NUM_SLOTS];

  assign src_reg[0] = iss_src1;
  assign src_reg[1] = iss_src2;
  assign iss_fire   = |alloc_oh;
  assign iss_ready  = can_alloc;

  rs_reg_status #(
    .NUM_REGS (NUM_REGS),
    .DATA_W   (DATA_W),
    .TAG_W    (TAG_W)
  ) status_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .ren_en     (iss_fire),
    .ren_reg    (iss_dst),
    .ren_tag    (iss_tag),
    .cdb_valid  (cdb_valid),
    .cdb_tag    (cdb_tag),
    .cdb_data   (cdb_data),
    .src_reg    (src_reg),
    .src_have   (src_have),
    .src_val    (src_val),
    .src_tag    (src_tag),
    .rd_reg     (rd_reg),
    .rd_data    (rd_data),
    .rd_pending (rd_pending)
  );

  rs_pick #(
    .NUM_SLOTS (NUM_SLOTS)
  ) pick_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_valid (slot_valid),
    .slot_ready (slot_ready),
    .alloc_req  (iss_valid),
    .fu_ready   (fu_ready),
    .can_alloc  (can_alloc),
    .alloc_oh   (alloc_oh),
    .disp_oh    (disp_oh)
  );

  generate
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_slot
      rs_slot #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W),
        .OP_W   (OP_W)
      ) slot_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (alloc_oh[g]),
        .ld_op     (iss_op),
        .ld_have   (src_have),
        .ld_val    (src_val),
        .ld_tag    (src_tag),
        .ld_dst    (iss_tag),
        .cdb_valid (cdb_valid),
        .cdb_tag   (cdb_tag),
        .cdb_data  (cdb_data),
        .release_i (disp_oh[g]),
        .valid_o   (slot_valid[g]),
        .ready_o   (slot_ready[g]),
        .op_o      (s_op[g]),
        .opa_o     (s_a[g]),
        .opb_o     (s_b[g]),
        .dst_o     (s_dst[g])
      );
    end
  endgenerate

  always_comb begin
    disp_op  = '0;
    disp_a   = '0;
    disp_b   = '0;
    disp_tag = '0;
    for (int g = 0; g < NUM_SLOTS; g++) begin
      if (disp_oh[g]) begin
        disp_op  = disp_op  | s_op[g];
        disp_a   = disp_a   | s_a[g];
        disp_b   = disp_b   | s_b[g];
        disp_tag = disp_tag | s_dst[g];
      end
    end
  end

  assign disp_valid = |disp_oh;

  // R4: the unit only receives work when it is free
  p_disp_unit_free_r4: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |-> fu_ready);

  // R9: a refused request renames nothing
  p_refused_no_fire_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && !iss_ready) |-> !iss_fire);

  // R10: a dispatch leaves room for the next issue
  p_disp_frees_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (disp_valid && !iss_valid) |=> iss_ready);

endmodule

// File: tb/rename_station_tb_top.sv
`timescale 1ns/1ps
module rename_station_tb_top;
  localparam int NS = 4, NR = 8, DW = 16, TW = 4, OW = 3, RW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic iss_valid, iss_ready;
  logic [OW-1:0] iss_op;
  logic [RW-1:0] iss_src1, iss_src2, iss_dst;
  logic [TW-1:0] iss_tag;
  logic cdb_valid;
  logic [TW-1:0] cdb_tag;
  logic [DW-1:0] cdb_data;
  logic fu_ready, disp_valid;
  logic [OW-1:0] disp_op;
  logic [DW-1:0] disp_a, disp_b;
  logic [TW-1:0] disp_tag;
  logic [RW-1:0] rd_reg;
  logic [DW-1:0] rd_data;
  logic rd_pending;

  always #2.5 clk = ~clk;

  rename_station #(.NUM_SLOTS(NS), .NUM_REGS(NR), .DATA_W(DW), .TAG_W(TW), .OP_W(OW)) dut_i (
    .clk(clk), .rst_n(rst_n), .iss_valid(iss_valid), .iss_ready(iss_ready), .iss_op(iss_op),
    .iss_src1(iss_src1), .iss_src2(iss_src2), .iss_dst(iss_dst), .iss_tag(iss_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_data(cdb_data), .fu_ready(fu_ready),
    .disp_valid(disp_valid), .disp_op(disp_op), .disp_a(disp_a), .disp_b(disp_b),
    .disp_tag(disp_tag), .rd_reg(rd_reg), .rd_data(rd_data), .rd_pending(rd_pending));

  typedef struct {
    logic [OW-1:0] op;
    logic [DW-1:0] a;
    logic [DW-1:0] b;
    logic [TW-1:0] tag;
    string         req;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, expv);
    end
  endtask

  task automatic push(input logic [OW-1:0] op, input logic [DW-1:0] a,
                      input logic [DW-1:0] b, input logic [TW-1:0] tag, input string req);
    exp_t e;
    e.op = op; e.a = a; e.b = b; e.tag = tag; e.req = req;
    exp_q.push_back(e);
  endtask

  // Driver: called on a falling edge, returns on the next falling edge
  task automatic issue(input logic [OW-1:0] op, input logic [RW-1:0] s1, input logic [RW-1:0] s2,
                       input logic [RW-1:0] dst, input logic [TW-1:0] tag);
    iss_valid = 1'b1; iss_op = op; iss_src1 = s1; iss_src2 = s2; iss_dst = dst; iss_tag = tag;
    @(negedge clk);
    iss_valid = 1'b0;
  endtask

  task automatic bcast(input logic [TW-1:0] tag, input logic [DW-1:0] data);
    cdb_valid = 1'b1; cdb_tag = tag; cdb_data = data;
    @(negedge clk);
    cdb_valid = 1'b0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd_check(input logic [RW-1:0] r, input logic [DW-1:0] v, input bit pend, input string req);
    rd_reg = r;
    #0.5;
    chk(rd_data == v, req, $sformatf("r%0d value", r), 64'(rd_data), 64'(v));
    chk(rd_pending == pend, req, $sformatf("r%0d pending", r), 64'(rd_pending), 64'(pend));
  endtask

  task automatic no_disp(input string req);
    #0.5;
    chk(disp_valid == 1'b0, req, "disp_valid", 64'(disp_valid), 64'd0);
  endtask

  // Monitor: samples 1.5 ns after each falling edge, ahead of the rising edge
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (rst_n && disp_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R10", "unexpected dispatch tag", 64'(disp_tag), 64'd0);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          chk({disp_op, disp_a, disp_b, disp_tag} == {e.op, e.a, e.b, e.tag}, e.req,
              "dispatch {op,a,b,tag}", 64'({disp_op, disp_a, disp_b, disp_tag}),
              64'({e.op, e.a, e.b, e.tag}));
        end
      end
    end
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; iss_valid = 1'b0; iss_op = '0; iss_src1 = '0; iss_src2 = '0; iss_dst = '0;
    iss_tag = '0; cdb_valid = 1'b0; cdb_tag = '0; cdb_data = '0; fu_ready = 1'b0; rd_reg = '0;
    step(3);
    rst_n = 1'b1;
    step(1);

    // R1: reset state
    #0.5;
    chk(iss_ready == 1'b1, "R1", "iss_ready", 64'(iss_ready), 64'd1);
    chk(disp_valid == 1'b0, "R1", "disp_valid", 64'(disp_valid), 64'd0);
    for (int r = 0; r < NR; r++) rd_check(RW'(r), '0, 1'b0, "R1");

    // R2, R5, R4: ready operands, rename, unit busy
    step(1);
    push(3'd1, 16'h0, 16'h0, 4'd1, "R2");
    issue(3'd1, 3'd1, 3'd2, 3'd3, 4'd1);
    rd_check(3'd3, 16'h0, 1'b1, "R5");
    no_disp("R4");
    step(1);
    fu_ready = 1'b1;
    step(2);
    bcast(4'd1, 16'h0055);
    rd_check(3'd3, 16'h0055, 1'b0, "R6");

    // R3: waiting on a producer tag
    step(1);
    fu_ready = 1'b0;
    push(3'd2, 16'h0055, 16'h0, 4'd2, "R2");
    issue(3'd2, 3'd3, 3'd4, 3'd4, 4'd2);
    push(3'd3, 16'h1234, 16'h0055, 4'd3, "R3");
    issue(3'd3, 3'd4, 3'd3, 3'd5, 4'd3);
    fu_ready = 1'b1;
    step(1);
    no_disp("R3");
    step(1);
    bcast(4'd2, 16'h1234);
    step(2);
    rd_check(3'd4, 16'h1234, 1'b0, "R6");

    // R8: broadcast in the issue cycle, R7: older entry first
    step(1);
    fu_ready = 1'b0;
    push(3'd4, 16'h0, 16'h0, 4'd5, "R7");
    issue(3'd4, 3'd0, 3'd0, 3'd6, 4'd5);
    cdb_valid = 1'b1; cdb_tag = 4'd5; cdb_data = 16'h0abc;
    push(3'd5, 16'h0abc, 16'h0abc, 4'd6, "R8");
    issue(3'd5, 3'd6, 3'd6, 3'd7, 4'd6);
    cdb_valid = 1'b0;
    rd_check(3'd6, 16'h0abc, 1'b0, "R6");
    rd_check(3'd7, 16'h0, 1'b1, "R5");
    step(1);
    fu_ready = 1'b1;
    step(3);

    // R7: oldest entry sits in a higher slot than a younger one
    fu_ready = 1'b0;
    push(3'd6, 16'h0055, 16'h1234, 4'd7, "R7");
    issue(3'd6, 3'd3, 3'd4, 3'd7, 4'd7);
    push(3'd7, 16'h1234, 16'h0abc, 4'd8, "R7");
    issue(3'd7, 3'd4, 3'd6, 3'd7, 4'd8);
    fu_ready = 1'b1;
    step(1);
    fu_ready = 1'b0;
    push(3'd0, 16'h0abc, 16'h0055, 4'd9, "R7");
    issue(3'd0, 3'd6, 3'd3, 3'd7, 4'd9);
    fu_ready = 1'b1;
    step(4);

    // R6: an older writer's broadcast does not reach the register
    fu_ready = 1'b0;
    push(3'd1, 16'h0, 16'h0, 4'd10, "R6");
    issue(3'd1, 3'd0, 3'd0, 3'd2, 4'd10);
    issue(3'd2, 3'd2, 3'd0, 3'd1, 4'd11);
    push(3'd3, 16'h0, 16'h0, 4'd12, "R6");
    issue(3'd3, 3'd0, 3'd0, 3'd2, 4'd12);
    fu_ready = 1'b1;
    step(3);
    no_disp("R3");
    step(1);
    push(3'd2, 16'h1111, 16'h0, 4'd11, "R3");
    bcast(4'd10, 16'h1111);
    rd_check(3'd2, 16'h0, 1'b1, "R6");
    step(2);
    bcast(4'd12, 16'h2222);
    rd_check(3'd2, 16'h2222, 1'b0, "R6");

    // R9, R10: full pool refuses, dispatch frees
    step(1);
    fu_ready = 1'b0;
    for (int k = 0; k < NS; k++) begin
      push(OW'(k + 4), 16'h0, 16'h0055, TW'(13 + k), "R9");
      issue(OW'(k + 4), 3'd0, 3'd3, 3'd5, TW'(13 + k));
    end
    #0.5;
    chk(iss_ready == 1'b0, "R9", "iss_ready when full", 64'(iss_ready), 64'd0);
    no_disp("R4");
    step(1);
    issue(3'd1, 3'd0, 3'd0, 3'd6, 4'd1);
    rd_check(3'd6, 16'h0abc, 1'b0, "R9");
    step(1);
    fu_ready = 1'b1;
    step(1);
    #0.5;
    chk(iss_ready == 1'b1, "R10", "iss_ready after dispatch", 64'(iss_ready), 64'd1);
    step(6);
    chk(exp_q.size() == 0, "R10", "entries never dispatched", 64'(exp_q.size()), 64'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule